// File: doc/BRIEF.md
# Teletext Bit Clock Recovery

This block recovers the bit sampling instants of a vertical-blanking text service from a stream of already-sliced bits. A phase accumulator, clocked by the 20.25 MHz system clock, adds a programmable increment every cycle. A full bit period is 2048 whole accumulator steps, and the increment carries 8 further fractional bits. Every wrap of the accumulator produces a one-cycle bit strobe, so the increment alone sets the bit rate: increment = 2048 × 256 × bit_rate / 20.25 MHz.

While the service detector holds the sync window open, which covers the clock run-in and the framing code, every transition of the sliced bit pulls the accumulator phase part of the way toward mid-bit. Strobes then fall at the centre of each bit. Once the window closes, the phase free-runs. From that point a byte strobe marks every eighth bit strobe, which gives the byte rate (bit rate / 8) of the data that follows the framing code.

Top module: `ttbr_bit_clock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator phase, the byte counter and both strobes clear. After the edge both strobe outputs are 0.
- R2: The 19-bit phase is 11 whole bits over 8 fraction bits, with a full bit period of 2^19 fraction units. On every clock the increment is added to the phase modulo 2^19. `bit_stb_o` is high for exactly the cycle after an edge at which that sum reached 2^19 or more.
- R3: With increment 179617 (6.9375 Mbit/s) and a starting phase of 0, the number of bit strobes after N clocks is floor(N × 179617 / 2^19).
- R4: At an edge where `sync_win_i` is 1 and `sliced_bit_i` differs from its value at the previous edge, the wrapped sum s is replaced by s + ((2^18 − s) >>> 2), using an arithmetic shift. This moves it a quarter of the way to mid-bit (2^18). The previous bit value is 0 after reset.
- R5: While `sync_win_i` is 0, transitions of `sliced_bit_i` have no effect on the phase or on the strobes.
- R6: An edge with `sync_win_i` 0 that follows an edge with `sync_win_i` 1 arms the byte counter and clears it. From then on, every eighth bit strobe also raises `byte_stb_o`, in the same cycle as that bit strobe.
- R7: While `sync_win_i` is 1, `byte_stb_o` stays 0 and the counter is disarmed. No byte strobe fires after reset until a window has opened and closed.
- R8: A new value of `inc_i` is used from the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20.25 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sliced_bit_i | input | 1 | Sliced data bit, one sample per clock |
| sync_win_i | input | 1 | Run-in and framing-code window from the service detector |
| inc_i | input | 19 | Phase increment per clock, in 1/256 accumulator steps |
| bit_stb_o | output | 1 | One-cycle strobe at the recovered bit centre |
| byte_stb_o | output | 1 | One-cycle strobe on every eighth bit strobe after the window closes |

## Verification
On every cycle, the assertions check three things. A strobe follows exactly the phase overflow, and the phase advances by exactly the increment whenever no pull is applied. Byte strobes never fire during the window and never fire without a bit strobe.

Only the bench's scenarios can show the rest, by comparing the outputs against a behavioural reference on every clock. These are the size of the pull toward mid-bit and the long-run strobe count at the real teletext increment. They also include the byte counting restarting at each window close, and the bit transitions being ignored outside the window.

// File: rtl/ttbr_pkg.sv
// Package: default geometry shared by the bit clock recovery modules.
// Assumes: one bit period is 2^ACC_W whole steps, each split in 2^FRAC_W parts.
package ttbr_pkg;
    localparam int unsigned TTBR_ACC_W    = 11;  // whole steps per bit: 2048
    localparam int unsigned TTBR_FRAC_W   = 8;   // fractional increment bits
    localparam int unsigned TTBR_PULL_SH  = 2;   // pull = error / 2^PULL_SH
    localparam int unsigned TTBR_BYTE_LEN = 8;   // bit strobes per byte strobe
endpackage

// File: rtl/ttbr_edge_det.sv
// Edge detector: flags a change of the sliced bit and the closing of the
// sync window, each relative to the value held at the previous clock edge.
// Assumes: inputs are already synchronous to clk.
module ttbr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic win_i,
    output logic edge_o,
    output logic win_fall_o
);
    logic bit_q;
    logic win_q;

    // Hold the previous bit and window values for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            win_q <= 1'b0;
        end else begin
            bit_q <= bit_i;
            win_q <= win_i;
        end
    end

    // Transition of the sliced bit and closing of the window.
    always_comb begin
        edge_o     = bit_i ^ bit_q;
        win_fall_o = win_q & ~win_i;
    end
endmodule

// File: rtl/ttbr_phase_acc.sv
// Phase accumulator: adds the increment each clock, emits a registered strobe
// on wrap and, when asked, pulls the wrapped phase toward mid-bit.
// Assumes: inc_i is below one full period (bit rate below clock rate).
module ttbr_phase_acc #(
    parameter int unsigned ACC_W   = ttbr_pkg::TTBR_ACC_W,
    parameter int unsigned FRAC_W  = ttbr_pkg::TTBR_FRAC_W,
    parameter int unsigned PULL_SH = ttbr_pkg::TTBR_PULL_SH,
    localparam int unsigned PH_W   = ACC_W + FRAC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] inc_i,
    input  logic            pull_en_i,
    output logic            carry_o,
    output logic            bit_stb_o
);
    localparam logic [PH_W-1:0] HALF_V = PH_W'(1) << (PH_W - 1);

    logic [PH_W-1:0]        acc_q;
    logic [PH_W:0]          sum_w;
    logic [PH_W-1:0]        base_w;
    logic signed [PH_W:0]   err_w;
    logic [PH_W-1:0]        pull_w;
    logic [PH_W-1:0]        acc_d;

    // Add the increment, split off the wrap and compute the mid-bit pull.
    always_comb begin
        sum_w   = {1'b0, acc_q} + {1'b0, inc_i};
        base_w  = sum_w[PH_W-1:0];
        carry_o = sum_w[PH_W];
        err_w   = $signed({1'b0, HALF_V}) - $signed({1'b0, base_w});
        pull_w  = PH_W'(err_w >>> PULL_SH);
        acc_d   = pull_en_i ? (base_w + pull_w) : base_w;
    end

    // Phase register and registered bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            bit_stb_o <= 1'b0;
        end else begin
            acc_q     <= acc_d;
            bit_stb_o <= carry_o;
        end
    end

    AST_STB_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((({1'b0, acc_q} + {1'b0, inc_i}) >> PH_W) != 0) |=> bit_stb_o); // R2
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_en_i |=> acc_q == PH_W'($past(acc_q) + $past(inc_i))); // R5
endmodule

// File: rtl/ttbr_byte_cnt.sv
// Byte counter: armed when the sync window closes, it counts bit wraps and
// raises a registered byte strobe on every BYTE_LEN-th one.
// Assumes: carry_i is the same-cycle wrap that produces the bit strobe.
module ttbr_byte_cnt #(
    parameter int unsigned BYTE_LEN = ttbr_pkg::TTBR_BYTE_LEN,
    localparam int unsigned CNT_W   = (BYTE_LEN > 1) ? $clog2(BYTE_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_i,
    input  logic win_fall_i,
    input  logic carry_i,
    output logic byte_stb_o
);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(BYTE_LEN - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_w;

    // Final bit of a byte while counting.
    always_comb begin
        last_w = armed_q & ~win_i & carry_i & (cnt_q == LAST_V);
    end

    // Arm on window close, disarm inside the window, count wraps otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            cnt_q      <= '0;
            byte_stb_o <= 1'b0;
        end else begin
            byte_stb_o <= last_w;
            if (win_i) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (win_fall_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (armed_q && carry_i) begin
                cnt_q   <= last_w ? '0 : cnt_q + 1'b1;
            end
        end
    end

    AST_NO_BYTE_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb_o |-> !$past(win_i)); // R7
endmodule

// File: rtl/ttbr_bit_clock.sv
// Top: teletext bit clock recovery. Joins edge detection, the phase
// accumulator with mid-bit pull during the sync window, and the byte counter.
// Assumes: sync_win_i covers clock run-in and framing code only.
module ttbr_bit_clock #(
    parameter int unsigned ACC_W    = ttbr_pkg::TTBR_ACC_W,
    parameter int unsigned FRAC_W   = ttbr_pkg::TTBR_FRAC_W,
    parameter int unsigned PULL_SH  = ttbr_pkg::TTBR_PULL_SH,
    parameter int unsigned BYTE_LEN = ttbr_pkg::TTBR_BYTE_LEN,
    localparam int unsigned PH_W    = ACC_W + FRAC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sliced_bit_i,
    input  logic            sync_win_i,
    input  logic [PH_W-1:0] inc_i,
    output logic            bit_stb_o,
    output logic            byte_stb_o
);
    logic edge_w;
    logic fall_w;
    logic pull_w;
    logic carry_w;

    // Pull only on a bit transition inside the sync window.
    always_comb begin
        pull_w = sync_win_i & edge_w;
    end

    ttbr_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (sliced_bit_i),
        .win_i      (sync_win_i),
        .edge_o     (edge_w),
        .win_fall_o (fall_w)
    );

    ttbr_phase_acc #(
        .ACC_W   (ACC_W),
        .FRAC_W  (FRAC_W),
        .PULL_SH (PULL_SH)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (inc_i),
        .pull_en_i (pull_w),
        .carry_o   (carry_w),
        .bit_stb_o (bit_stb_o)
    );

    ttbr_byte_cnt #(
        .BYTE_LEN (BYTE_LEN)
    ) u_byte (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_i      (sync_win_i),
        .win_fall_i (fall_w),
        .carry_i    (carry_w),
        .byte_stb_o (byte_stb_o)
    );

    AST_BYTE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb_o |-> bit_stb_o); // R6
endmodule

// File: tb/tb_ttbr_bit_clock.sv
module tb_ttbr_bit_clock;
    localparam int CLK_PERIOD = 10;
    localparam longint FULL = 64'd1 << 19;
    localparam longint HALF = 64'd1 << 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sliced_bit_i = 1'b0;
    logic        sync_win_i = 1'b0;
    logic [18:0] inc_i = '0;
    logic        bit_stb_o;
    logic        byte_stb_o;

    int     n_checks = 0;
    int     n_fail = 0;
    int     cycles = 0;
    string  cur_req = "R1";

    // Behavioural reference state.
    longint m_acc = 0;
    bit     m_bitq = 0, m_winq = 0, m_armed = 0, m_bit_stb = 0, m_byte_stb = 0;
    int     m_cnt = 0;

    ttbr_bit_clock dut (
        .clk(clk), .rst_n(rst_n), .sliced_bit_i(sliced_bit_i),
        .sync_win_i(sync_win_i), .inc_i(inc_i),
        .bit_stb_o(bit_stb_o), .byte_stb_o(byte_stb_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        longint s, e;
        bit carry, fall, last;
        if (!rst_n) begin
            m_acc = 0; m_bitq = 0; m_winq = 0; m_armed = 0; m_cnt = 0;
            m_bit_stb = 0; m_byte_stb = 0;
        end else begin
            s = m_acc + longint'(inc_i);
            carry = (s >= FULL);
            s = s % FULL;
            if (sync_win_i && (sliced_bit_i != m_bitq)) begin
                e = HALF - s;
                s = s + (e >>> 2);
            end
            fall = m_winq && !sync_win_i;
            last = m_armed && !sync_win_i && carry && (m_cnt == 7);
            m_byte_stb = last;
            m_bit_stb = carry;
            if (sync_win_i) begin m_armed = 0; m_cnt = 0; end
            else if (fall) begin m_armed = 1; m_cnt = 0; end
            else if (m_armed && carry) m_cnt = (m_cnt + 1) % 8;
            m_acc = s; m_bitq = sliced_bit_i; m_winq = sync_win_i;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock, then compare outputs with the reference away from the edge.
    task automatic tick();
        @(posedge clk); #1;
        cycles++;
        check(cur_req, "bit_stb", longint'(bit_stb_o), longint'(m_bit_stb));
        check(cur_req, "byte_stb", longint'(byte_stb_o), longint'(m_byte_stb));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sync_win_i = 0; sliced_bit_i = 0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int nb, ny, first;
        longint expn;
        // R1: reset state
        cur_req = "R1";
        inc_i = 19'd65536;
        do_reset();
        check("R1", "bit_stb after reset", longint'(bit_stb_o), 0);
        check("R1", "byte_stb after reset", longint'(byte_stb_o), 0);

        // R2: exact period 8 with increment 2^16
        cur_req = "R2";
        nb = 0;
        for (int i = 0; i < 800; i++) begin tick(); nb += bit_stb_o; end
        check("R2", "strobes in 800 clocks", nb, 100);

        // R3: teletext rate increment
        cur_req = "R3";
        do_reset();
        inc_i = 19'd179617;
        nb = 0;
        for (int i = 0; i < 20250; i++) begin tick(); nb += bit_stb_o; end
        expn = (longint'(20250) * 179617) / FULL;
        check("R3", "strobes at 6.9375 Mbit/s", nb, expn);

        // R5: transitions outside the window are ignored
        cur_req = "R5";
        inc_i = 19'd65536;
        do_reset();
        nb = 0;
        for (int i = 0; i < 80; i++) begin
            sliced_bit_i = ~sliced_bit_i; tick(); nb += bit_stb_o;
        end
        check("R5", "strobes with toggling bits", nb, 10);

        // R4: two pulls from phase 0 give 114688, then 7 clocks to wrap
        cur_req = "R4";
        do_reset();
        inc_i = 0; sync_win_i = 1;
        sliced_bit_i = 1; tick();
        sliced_bit_i = 0; tick();
        sync_win_i = 0; inc_i = 19'd65536;
        first = 0;
        for (int i = 1; i <= 8; i++) begin
            tick();
            if (bit_stb_o && first == 0) first = i;
        end
        check("R4", "clocks to first strobe after pulls", first, 7);

        // R6: bytes counted from the window close
        cur_req = "R6";
        do_reset();
        sync_win_i = 1;
        for (int i = 0; i < 20; i++) begin sliced_bit_i = i[1]; tick(); end
        sync_win_i = 0; sliced_bit_i = 0;
        tick();
        nb = 0; ny = 0; first = 0;
        for (int i = 0; i < 640; i++) begin
            tick();
            nb += bit_stb_o; ny += byte_stb_o;
            if (byte_stb_o && first == 0) first = nb;
        end
        check("R6", "bit strobe index of first byte strobe", first, 8);
        check("R6", "byte strobes over 80 bits", ny, 10);

        // R7: window reopened mid-byte holds off byte strobes
        cur_req = "R7";
        for (int i = 0; i < 20; i++) tick();
        sync_win_i = 1; ny = 0;
        for (int i = 0; i < 40; i++) begin tick(); ny += byte_stb_o; end
        check("R7", "byte strobes inside window", ny, 0);
        sync_win_i = 0;
        do_reset();
        ny = 0;
        for (int i = 0; i < 200; i++) begin tick(); ny += byte_stb_o; end
        check("R7", "byte strobes without a window", ny, 0);

        // R8: increment changes take effect at once
        cur_req = "R8";
        do_reset();
        for (int k = 0; k < 20; k++) begin
            inc_i = 19'(32768 + k * 20000);
            for (int i = 0; i < 13; i++) tick();
        end

        // Mixed random traffic against the reference (R4, R6)
        cur_req = "R4,R6";
        do_reset();
        for (int k = 0; k < 60; k++) begin
            inc_i = 19'($urandom_range(150000, 200000));
            sync_win_i = 1;
            for (int i = 0; i < 40; i++) begin sliced_bit_i = ($urandom_range(0, 3) == 0) ^ sliced_bit_i; tick(); end
            sync_win_i = 0;
            for (int i = 0; i < 60; i++) begin sliced_bit_i = 1'($urandom_range(0, 1)); tick(); end
        end

        finish_run();
    end
endmodule